// File: doc/BRIEF.md
# Enhanced Parallel Port Cycle Engine

This block sits next to a standard parallel-port register set. It turns host accesses to the address-cycle offset (3) and the data-cycle offset (4) into byte-wide transfers toward the peripheral. Each transfer uses an active-low write line, an active-low data strobe, an active-low address strobe and a wait input from the peripheral. The data offset also takes 2-byte and 4-byte host accesses. These are split into byte cycles with the low byte first, and read bytes are packed back in the same order. The block also owns the status offset (1). It keeps a sticky timeout flag that takes the place of status bit 0.

No cycle starts unless the control register value from the neighbouring block holds an exact mode pattern. The pattern for reads differs from the pattern for writes. When a handshake stalls for longer than a programmable count, the rest of the access is dropped, the sticky flag is set and the host still receives a completion.

The host side is a request channel with valid/ready. The host holds `req_valid` and its fields steady until `req_ready` is high at a clock edge. `req_ready` is high only while the engine is idle, so it stays low through the whole multi-byte sequence. The response channel has no back-pressure. `rsp_valid` is high for exactly one cycle and the host must take `rsp_rdata` in that cycle.

Top module: `epp_cycle_engine`

## Requirements
- R1: An accepted access at offset 3 runs exactly one byte cycle using the address strobe (`epp_astb_n` low), whatever `req_size` says. An access at offset 4 uses the data strobe (`epp_dstb_n` low). The two strobes are never low together.
- R2: A write at offset 3 or 4 starts bus activity only when `ctrl_reg & 8'h2F == 8'h04`. Control bits are: 5 direction, 3 select, 2 init, 1 autofeed, 0 strobe. Otherwise no strobe moves, and the response comes one cycle after acceptance with `rsp_rdata` = 0.
- R3: A read at offset 3 or 4 starts bus activity only when `ctrl_reg & 8'h2F == 8'h24`. Otherwise no strobe moves, and the response one cycle later is all ones for the access width: 0xFF, 0xFFFF or 0xFFFFFFFF.
- R4: In a byte cycle the strobe stays low until `epp_wait` is seen high, and a read latches `epp_din` in that cycle. The strobe then rises, and the next byte (or the response) waits until `epp_wait` is seen low.
- R5: If `epp_wait` fails to change within `tmo_limit`+1 cycles in either phase, the remaining bytes are dropped and `tmo_flag` is set. The response follows in the same cycle, with all ones of the access width for reads and 0 for writes.
- R6: The data offset uses `req_size` as follows: 0 moves 1 byte, 1 moves 2 bytes, 2 or 3 moves 4 bytes. Byte i of a write is `req_wdata[8i+7:8i]` on `epp_dout`, and read byte i lands in `rsp_rdata[8i+7:8i]`, with byte 0 first.
- R7: A read at offset 1 returns `{sts_pins[7:1], tmo_flag}` in bits 7:0 and zeros above. The flag is 0 after reset.
- R8: A write at offset 1 with bit 0 set clears the flag. With bit 0 clear it leaves the flag unchanged. Nothing else clears the flag.
- R9: `req_ready` is low from the acceptance edge until the response cycle has passed, and `rsp_valid` is a one-cycle pulse. A read at any other offset answers all ones one cycle after acceptance.
- R10: `epp_write_n` is low and `epp_doe` is high only while a write's byte cycles run, in both strobe and release phases. While idle, all three strobes are high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctrl_reg | input | 8 | Current control register value from the standard block |
| sts_pins | input | 8 | Peripheral status lines as seen by the standard block |
| tmo_limit | input | CNT_W | Handshake timeout count |
| req_valid | input | 1 | Host request valid |
| req_ready | output | 1 | Engine idle and able to accept a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 3 | Register offset |
| req_size | input | 2 | Access width code (see R6) |
| req_wdata | input | DATA_W | Write data |
| rsp_valid | output | 1 | One-cycle completion pulse |
| rsp_rdata | output | DATA_W | Read data (0 for writes) |
| tmo_flag | output | 1 | Sticky timeout flag |
| epp_write_n | output | 1 | Active-low write direction line |
| epp_dstb_n | output | 1 | Active-low data strobe |
| epp_astb_n | output | 1 | Active-low address strobe |
| epp_dout | output | 8 | Byte driven toward the peripheral |
| epp_doe | output | 1 | Output enable for `epp_dout` |
| epp_wait | input | 1 | Peripheral handshake line |
| epp_din | input | 8 | Byte from the peripheral |

## Verification
Byte cycles run with a peripheral that answers at once, one that answers after a few cycles, and one with a slow release. These patterns separate the strobe and release phases and show whether the engine samples `epp_wait` too early. Writes and reads of 1, 2 and 4 bytes, fed distinct byte values, expose byte-order and packing faults. A peripheral that never answers exercises the timeout, the dropped bytes and the sticky flag with its clear rules. Control values just off each mode pattern confirm that gated accesses stay silent on the bus and return the right fill value.

// File: rtl/epp_pkg.sv
package epp_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_STB, ST_REL, ST_RSP} epp_st_e;

  localparam logic [2:0] OFS_STATUS = 3'd1;
  localparam logic [2:0] OFS_EADDR  = 3'd3;
  localparam logic [2:0] OFS_EDATA  = 3'd4;

  // control bits that take part in the mode check: dir, select, init, autofeed, strobe
  localparam logic [7:0] MODE_MASK = 8'h2F;
  localparam logic [7:0] MODE_WR   = 8'h04;
  localparam logic [7:0] MODE_RD   = 8'h24;
endpackage

// File: rtl/epp_mode_gate.sv
module epp_mode_gate
  import epp_pkg::*;
(
  input  logic [7:0] ctrl_i,
  output logic       wr_ok_o,
  output logic       rd_ok_o
);
  logic [7:0] masked;
  assign masked  = ctrl_i & MODE_MASK;
  assign wr_ok_o = (masked == MODE_WR);
  assign rd_ok_o = (masked == MODE_RD);
endmodule

// File: rtl/epp_tmo_flag.sv
module epp_tmo_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic clr_i,
  output logic flag_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     flag_o <= 1'b0;
    else if (set_i) flag_o <= 1'b1;
    else if (clr_i) flag_o <= 1'b0;
  end
endmodule

// File: rtl/epp_xfer_fsm.sv
module epp_xfer_fsm
  import epp_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int CNT_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [2:0]        req_addr,
  input  logic [1:0]        req_size,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_rdata,
  input  logic [7:0]        sts_pins,
  input  logic              flag_i,
  output logic              tmo_set_o,
  output logic              flag_clr_o,
  input  logic              wr_ok_i,
  input  logic              rd_ok_i,
  input  logic [CNT_W-1:0]  tmo_limit,
  output logic              write_n,
  output logic              dstb_n,
  output logic              astb_n,
  output logic [7:0]        dout,
  output logic              doe,
  input  logic              wait_i,
  input  logic [7:0]        din
);
  localparam int NB    = DATA_W / 8;
  localparam int IDX_W = (NB > 1) ? $clog2(NB) : 1;

  epp_st_e           st;
  logic [IDX_W-1:0]  idx, last;
  logic [CNT_W-1:0]  cnt;
  logic              is_wr, is_adr;
  logic [DATA_W-1:0] wdata, rdata;

  logic              accept, is_epp, allowed, tmo_hit;
  logic [IDX_W-1:0]  new_last;
  logic [DATA_W-1:0] new_ones, cur_ones;

  function automatic logic [DATA_W-1:0] ones_upto(input logic [IDX_W-1:0] l);
    logic [DATA_W-1:0] m;
    for (int b = 0; b < NB; b++) m[b*8 +: 8] = (b <= int'(l)) ? 8'hFF : 8'h00;
    return m;
  endfunction

  assign accept  = req_valid && (st == ST_IDLE);
  assign is_epp  = (req_addr == OFS_EADDR) || (req_addr == OFS_EDATA);
  assign allowed = req_write ? wr_ok_i : rd_ok_i;

  always_comb begin
    if (req_addr == OFS_EADDR || req_size == 2'd0) new_last = '0;
    else if (req_size == 2'd1)                      new_last = IDX_W'(1);
    else                                            new_last = IDX_W'(NB - 1);
  end
  assign new_ones = ones_upto(new_last);
  assign cur_ones = ones_upto(last);

  assign tmo_hit    = (cnt == tmo_limit) &&
                      (((st == ST_STB) && !wait_i) || ((st == ST_REL) && wait_i));
  assign tmo_set_o  = tmo_hit;
  assign flag_clr_o = accept && req_write && (req_addr == OFS_STATUS) && req_wdata[0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= ST_IDLE;
      idx    <= '0;
      last   <= '0;
      cnt    <= '0;
      is_wr  <= 1'b0;
      is_adr <= 1'b0;
      wdata  <= '0;
      rdata  <= '0;
    end else begin
      unique case (st)
        ST_IDLE: if (accept) begin
          is_wr  <= req_write;
          is_adr <= (req_addr == OFS_EADDR);
          wdata  <= req_wdata;
          idx    <= '0;
          cnt    <= '0;
          last   <= new_last;
          if (is_epp && allowed) begin
            st    <= ST_STB;
            rdata <= '0;
          end else begin
            st <= ST_RSP;
            if (req_write)                    rdata <= '0;
            else if (req_addr == OFS_STATUS)  rdata <= DATA_W'({sts_pins[7:1], flag_i});
            else if (is_epp)                  rdata <= new_ones;
            else                              rdata <= '1;
          end
        end
        ST_STB: begin
          if (wait_i) begin
            if (!is_wr) rdata[{idx, 3'b000} +: 8] <= din;
            st  <= ST_REL;
            cnt <= '0;
          end else if (tmo_hit) begin
            st <= ST_RSP;
            if (!is_wr) rdata <= cur_ones;
          end else begin
            cnt <= CNT_W'(cnt + 1'b1);
          end
        end
        ST_REL: begin
          if (!wait_i) begin
            cnt <= '0;
            if (idx == last) st <= ST_RSP;
            else begin
              idx <= IDX_W'(idx + 1'b1);
              st  <= ST_STB;
            end
          end else if (tmo_hit) begin
            st <= ST_RSP;
            if (!is_wr) rdata <= cur_ones;
          end else begin
            cnt <= CNT_W'(cnt + 1'b1);
          end
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  assign req_ready = (st == ST_IDLE);
  assign rsp_valid = (st == ST_RSP);
  assign rsp_rdata = rdata;
  assign dstb_n    = !((st == ST_STB) && !is_adr);
  assign astb_n    = !((st == ST_STB) && is_adr);
  assign write_n   = !(is_wr && ((st == ST_STB) || (st == ST_REL)));
  assign doe       = !write_n;
  assign dout      = wdata[{idx, 3'b000} +: 8];
endmodule

// File: rtl/epp_cycle_engine.sv
module epp_cycle_engine #(
  parameter int DATA_W = 32,
  parameter int CNT_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [7:0]        ctrl_reg,
  input  logic [7:0]        sts_pins,
  input  logic [CNT_W-1:0]  tmo_limit,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [2:0]        req_addr,
  input  logic [1:0]        req_size,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic              tmo_flag,
  output logic              epp_write_n,
  output logic              epp_dstb_n,
  output logic              epp_astb_n,
  output logic [7:0]        epp_dout,
  output logic              epp_doe,
  input  logic              epp_wait,
  input  logic [7:0]        epp_din
);
  logic wr_ok, rd_ok, tmo_set, flag_clr;

  epp_mode_gate i_gate (
    .ctrl_i  (ctrl_reg),
    .wr_ok_o (wr_ok),
    .rd_ok_o (rd_ok)
  );

  epp_tmo_flag i_flag (
    .clk    (clk),
    .rst_n  (rst_n),
    .set_i  (tmo_set),
    .clr_i  (flag_clr),
    .flag_o (tmo_flag)
  );

  epp_xfer_fsm #(.DATA_W(DATA_W), .CNT_W(CNT_W)) i_fsm (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .req_ready  (req_ready),
    .req_write  (req_write),
    .req_addr   (req_addr),
    .req_size   (req_size),
    .req_wdata  (req_wdata),
    .rsp_valid  (rsp_valid),
    .rsp_rdata  (rsp_rdata),
    .sts_pins   (sts_pins),
    .flag_i     (tmo_flag),
    .tmo_set_o  (tmo_set),
    .flag_clr_o (flag_clr),
    .wr_ok_i    (wr_ok),
    .rd_ok_i    (rd_ok),
    .tmo_limit  (tmo_limit),
    .write_n    (epp_write_n),
    .dstb_n     (epp_dstb_n),
    .astb_n     (epp_astb_n),
    .dout       (epp_dout),
    .doe        (epp_doe),
    .wait_i     (epp_wait),
    .din        (epp_din)
  );
endmodule

// File: rtl/epp_cycle_engine_chk.sv
module epp_cycle_engine_chk #(
  parameter int DATA_W = 32,
  parameter int CNT_W  = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic [7:0]        ctrl_reg,
  input logic              req_valid,
  input logic              req_ready,
  input logic              req_write,
  input logic [2:0]        req_addr,
  input logic [DATA_W-1:0] req_wdata,
  input logic              rsp_valid,
  input logic [DATA_W-1:0] rsp_rdata,
  input logic              tmo_flag,
  input logic              epp_write_n,
  input logic              epp_dstb_n,
  input logic              epp_astb_n
);
  logic acc, epp_ofs, clr_acc;
  assign acc     = req_valid && req_ready;
  assign epp_ofs = (req_addr == 3'd3) || (req_addr == 3'd4);
  assign clr_acc = acc && req_write && (req_addr == 3'd1) && req_wdata[0];

  p_single_strobe_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !(!epp_dstb_n && !epp_astb_n));

  p_write_gate_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && req_write && epp_ofs && ((ctrl_reg & 8'h2F) != 8'h04))
      |=> (epp_dstb_n && epp_astb_n && rsp_valid));

  p_read_gate_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && !req_write && epp_ofs && ((ctrl_reg & 8'h2F) != 8'h24))
      |=> (epp_dstb_n && epp_astb_n && rsp_valid && rsp_rdata[7:0] == 8'hFF));

  p_tmo_completes_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tmo_flag) |-> rsp_valid);

  p_flag_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
    clr_acc |=> !tmo_flag);

  p_flag_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (tmo_flag && !clr_acc) |=> tmo_flag);

  p_busy_after_accept_r9: assert property (@(posedge clk) disable iff (!rst_n)
    acc |=> !req_ready);

  p_rsp_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> (!rsp_valid && req_ready));

  p_idle_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (epp_write_n && epp_dstb_n && epp_astb_n));
endmodule

bind epp_cycle_engine epp_cycle_engine_chk #(.DATA_W(DATA_W), .CNT_W(CNT_W)) i_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .ctrl_reg    (ctrl_reg),
  .req_valid   (req_valid),
  .req_ready   (req_ready),
  .req_write   (req_write),
  .req_addr    (req_addr),
  .req_wdata   (req_wdata),
  .rsp_valid   (rsp_valid),
  .rsp_rdata   (rsp_rdata),
  .tmo_flag    (tmo_flag),
  .epp_write_n (epp_write_n),
  .epp_dstb_n  (epp_dstb_n),
  .epp_astb_n  (epp_astb_n)
);

// File: tb/test_epp_cycle_engine.sv
module test_epp_cycle_engine;
  localparam int DW = 32;
  localparam int CW = 8;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic          rst_n = 1'b0;
  logic [7:0]    ctrl_reg = 8'hCC;
  logic [7:0]    sts_pins = 8'h5B;
  logic [CW-1:0] tmo_limit = 8'd6;
  logic          req_valid = 1'b0, req_write = 1'b0;
  logic [2:0]    req_addr = 3'd0;
  logic [1:0]    req_size = 2'd0;
  logic [DW-1:0] req_wdata = '0;
  logic          req_ready, rsp_valid, tmo_flag;
  logic [DW-1:0] rsp_rdata;
  logic          epp_write_n, epp_dstb_n, epp_astb_n, epp_doe;
  logic [7:0]    epp_dout;
  logic          epp_wait = 1'b0;
  logic [7:0]    epp_din = 8'h00;

  epp_cycle_engine #(.DATA_W(DW), .CNT_W(CW)) i_epp_cycle_engine (.*);

  int n_checks = 0, n_fail = 0;
  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // ---------------- reference model ----------------
  int          m_ph, m_idx, m_last, m_cnt, m_nb;
  bit          m_wr, m_adr, m_flag, m_tmo;
  logic [31:0] m_wd, m_rd, m_ones;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_ph = 0; m_idx = 0; m_last = 0; m_cnt = 0; m_wr = 0; m_adr = 0; m_flag = 0;
      m_wd = 0; m_rd = 0; m_ones = 0;
    end else begin
      m_tmo = 0;
      case (m_ph)
        0: if (req_valid) begin
          m_nb   = (req_addr == 3'd3 || req_size == 2'd0) ? 1 : (req_size == 2'd1 ? 2 : 4);
          m_ones = (m_nb == 1) ? 32'hFF : (m_nb == 2 ? 32'hFFFF : 32'hFFFF_FFFF);
          m_wr = req_write; m_adr = (req_addr == 3'd3); m_wd = req_wdata;
          m_last = m_nb - 1; m_idx = 0; m_cnt = 0;
          if ((req_addr == 3'd3 || req_addr == 3'd4) &&
              (req_write ? ((ctrl_reg & 8'h2F) == 8'h04) : ((ctrl_reg & 8'h2F) == 8'h24))) begin
            m_ph = 1; m_rd = 0;
          end else begin
            m_ph = 3;
            if (req_write) begin
              m_rd = 0;
              if (req_addr == 3'd1 && req_wdata[0]) m_flag = 0;
            end else if (req_addr == 3'd1) m_rd = {24'h0, sts_pins[7:1], m_flag};
            else if (req_addr == 3'd3 || req_addr == 3'd4) m_rd = m_ones;
            else m_rd = 32'hFFFF_FFFF;
          end
        end
        1: if (epp_wait) begin
          if (!m_wr) m_rd[m_idx*8 +: 8] = epp_din;
          m_ph = 2; m_cnt = 0;
        end else if (m_cnt == int'(tmo_limit)) m_tmo = 1;
        else m_cnt++;
        2: if (!epp_wait) begin
          m_cnt = 0;
          if (m_idx == m_last) m_ph = 3;
          else begin m_idx++; m_ph = 1; end
        end else if (m_cnt == int'(tmo_limit)) m_tmo = 1;
        else m_cnt++;
        default: m_ph = 0;
      endcase
      if (m_tmo) begin
        m_flag = 1; m_ph = 3;
        if (!m_wr) m_rd = m_ones;
      end
    end
  end

  // ---------------- peripheral and per-cycle compare ----------------
  bit         p_stuck = 0;
  int         p_dly = 0, p_rdly = 0, p_hold = 0, p_rhold = 0, p_served = 0;
  logic [7:0] p_base = 8'h00;
  logic [8:0] wq[$];

  always @(negedge clk) begin
    if (rst_n) begin
      chk("R9 ready", req_ready, m_ph == 0);
      chk("R4 data strobe", epp_dstb_n, !(m_ph == 1 && !m_adr));
      chk("R1 address strobe", epp_astb_n, !(m_ph == 1 && m_adr));
      chk("R10 write line", epp_write_n, !(m_wr && (m_ph == 1 || m_ph == 2)));
      chk("R10 output enable", epp_doe, m_wr && (m_ph == 1 || m_ph == 2));
      if (m_wr && (m_ph == 1 || m_ph == 2)) chk("R6 write byte", epp_dout, m_wd[m_idx*8 +: 8]);
      chk("R9 rsp_valid", rsp_valid, m_ph == 3);
      if (m_ph == 3) chk("R9 rsp data", rsp_rdata, m_rd);
      chk("R8 flag", tmo_flag, m_flag);
    end
    if (!epp_dstb_n || !epp_astb_n) begin
      if (!epp_wait && !p_stuck) begin
        if (p_hold >= p_dly) begin
          epp_wait = 1'b1;
          epp_din  = p_base + 8'(p_served);
          if (!epp_write_n) wq.push_back({!epp_astb_n, epp_dout});
          p_served++;
          p_hold = 0;
        end else p_hold++;
      end
    end else if (epp_wait) begin
      if (p_rhold >= p_rdly) begin epp_wait = 1'b0; p_rhold = 0; end
      else p_rhold++;
    end
  end

  task automatic access(input bit wr, input logic [2:0] a, input logic [1:0] sz,
                        input logic [31:0] wd, output logic [31:0] rd);
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_addr = a; req_size = sz; req_wdata = wd;
    @(negedge clk);
    req_valid = 1'b0;
    while (!rsp_valid) @(negedge clk);
    rd = rsp_rdata;
  endtask

  task automatic report;
    $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  endtask

  initial begin
    #(8 * 150000);
    n_checks++; n_fail++;
    $display("FAIL watchdog R9 actual=hung expected=done");
    report();
  end

  initial begin
    logic [31:0] r;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R7 flag after reset", tmo_flag, 1'b0);
    chk("R9 ready after reset", req_ready, 1'b1);
    chk("R10 idle strobes", {epp_write_n, epp_dstb_n, epp_astb_n}, 3'b111);

    access(0, 3'd1, 2'd0, 0, r);
    chk("R7 status read", r, 32'h0000_005A);

    // R2: default control blocks writes
    access(1, 3'd4, 2'd2, 32'hDEAD_BEEF, r);
    chk("R2 gated write data", r, 0);
    chk("R2 gated write no bus", wq.size(), 0);
    ctrl_reg = 8'h0C;  // select set: write pattern broken
    access(1, 3'd3, 2'd0, 32'h77, r);
    chk("R2 select blocks write", wq.size(), 0);

    // R3: write pattern blocks reads
    ctrl_reg = 8'h04;
    access(0, 3'd3, 2'd0, 0, r); chk("R3 gated byte read", r, 32'hFF);
    access(0, 3'd4, 2'd1, 0, r); chk("R3 gated half read", r, 32'hFFFF);
    access(0, 3'd4, 2'd2, 0, r); chk("R3 gated word read", r, 32'hFFFF_FFFF);
    chk("R3 no served bytes", p_served, 0);

    // R1 and R6 writes
    p_dly = 0; p_rdly = 0;
    access(1, 3'd3, 2'd2, 32'h1122_333C, r);
    chk("R1 one address byte", wq.size(), 1);
    if (wq.size() > 0) chk("R1 address byte", wq.pop_front(), {1'b1, 8'h3C});
    p_dly = 2; p_rdly = 1;
    access(1, 3'd4, 2'd2, 32'h1122_3344, r);
    chk("R6 four data bytes", wq.size(), 4);
    for (int i = 0; i < 4 && wq.size() > 0; i++)
      chk("R6 byte order", wq.pop_front(), {1'b0, 8'h44 - 8'(i * 8'h11)});
    access(1, 3'd4, 2'd3, 32'hA1B2_C3D4, r);
    chk("R6 size 3 moves four", wq.size(), 4);
    wq.delete();

    // R4 and R6 reads
    ctrl_reg = 8'hE4;  // upper bits outside mask do not matter
    p_dly = 0; p_rdly = 2; p_served = 0; p_base = 8'h40;
    access(0, 3'd4, 2'd1, 0, r);
    chk("R6 half read", r, 32'h0000_4140);
    p_dly = 3; p_rdly = 0; p_served = 0; p_base = 8'h80;
    access(0, 3'd4, 2'd2, 0, r);
    chk("R4 word read", r, 32'h8382_8180);
    p_served = 0; p_base = 8'h55;
    access(0, 3'd3, 2'd2, 0, r);
    chk("R1 address read one byte", r, 32'h0000_0055);
    chk("R1 served once", p_served, 1);

    // R5 timeout on read
    p_stuck = 1;
    access(0, 3'd4, 2'd2, 0, r);
    chk("R5 timeout read fill", r, 32'hFFFF_FFFF);
    @(negedge clk);
    chk("R5 flag set", tmo_flag, 1'b1);
    access(0, 3'd1, 2'd0, 0, r);
    chk("R7 status shows flag", r, 32'h0000_005B);

    // R8 clear rules
    access(1, 3'd1, 2'd0, 32'hFE, r);
    @(negedge clk);
    chk("R8 bit0 clear keeps flag", tmo_flag, 1'b1);
    access(1, 3'd1, 2'd0, 32'h01, r);
    @(negedge clk);
    chk("R8 bit0 set clears flag", tmo_flag, 1'b0);

    // R5 timeout on write, mid-sequence release stall
    ctrl_reg = 8'h04;
    access(1, 3'd4, 2'd1, 32'hBEEF, r);
    chk("R5 timeout write data", r, 0);
    chk("R5 write flag", tmo_flag, 1'b1);
    p_stuck = 0; p_dly = 0; p_rdly = 20;
    access(1, 3'd4, 2'd2, 32'h0102_0304, r);
    chk("R5 release stall drops rest", wq.size(), 1);
    wq.delete();
    p_rdly = 0;
    access(1, 3'd1, 2'd0, 32'h01, r);

    // R9 other offset
    access(0, 3'd0, 2'd0, 0, r);
    chk("R9 other offset fill", r, 32'hFFFF_FFFF);
    repeat (4) @(negedge clk);
    report();
  end
endmodule